// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the control and status byte of one DMA channel. A CPU reaches it over a simple bus. Each access either writes the whole byte or writes one addressed bit. The block keeps a sticky request-pending flag. That flag is set by a rising edge on the channel's selected hardware request input, or by software writing 1 to the trigger bit. It is cleared when the transfer engine accepts a start, or when software writes 0 to the flag-clear bit. The block also holds the channel enable, the flag-clear bit and an interrupt-mode select. It shows whether a transfer is in flight.

A small sequencer sits between this register and the transfer engine. It issues a start request and tracks the transfer until the engine reports completion. It has four named states:
- `ST_OFF`: the controller is powered down.
- `ST_IDLE`: powered, with nothing to start.
- `ST_ARMED`: enable and pending are both set, and a start is requested from the engine.
- `ST_BUSY`: the engine has accepted the start and the transfer is running.

The transitions are:
- Any state goes to `ST_OFF` when power drops.
- `ST_OFF` goes to `ST_IDLE` when power rises.
- `ST_IDLE` goes to `ST_ARMED` when enable and pending are both 1.
- `ST_ARMED` goes to `ST_BUSY` when the start is acknowledged.
- `ST_ARMED` goes back to `ST_IDLE` when enable or pending falls.
- `ST_BUSY` goes to `ST_IDLE` when the engine reports completion.

The channel interrupt output works in one of two modes. In the first mode it copies the request input at all times. In the second mode it is a one-cycle pulse that follows completion of an enabled transfer. The mode bit can only be changed while the controller is powered down.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the read data is 8'h00. Bits 7 and 6 always read 0. Bit 1 (trigger) always reads 0.
- R2: A byte write (`bus_bit`=0) loads bit 0 (enable) and bit 2 (flag-clear) from `bus_wdata`. Bit 4 (pending) and bit 3 (active) are read-only and unaffected by the write data.
- R3: A bit write (`bus_bit`=1) writes `bus_wdata[0]` into the bit numbered `bus_sel` and leaves every other bit unchanged. Bit writes to bits 7, 6, 4 and 3 have no effect.
- R4: The pending flag (bit 4) is set one clock after a rising edge of `hw_req`, or in the same edge as a write of 1 to bit 1. A `hw_req` that stays high does not set it again.
- R5: The pending flag is cleared by an accepted start (`eng_start_ack` while `start_req`=1), or by any write of 0 to bit 2. If a set and a clear happen in the same cycle, the flag ends up set.
- R6: While `pwr_on`=0, the pending, active, flag-clear and enable bits read 0 and writes to them are ignored. Bit 5 keeps its value.
- R7: A write to bit 5 (interrupt mode) takes effect only while `pwr_on`=0. Otherwise it is ignored.
- R8: With bit 5 = 0, `irq` equals `hw_req` in every sequencer state.
- R9: With bit 5 = 1, `irq` is 1 for exactly the one cycle after the clock edge at which `eng_done` is seen in `ST_BUSY` with enable = 1, and 0 otherwise.
- R10: `start_req` is 1 only in `ST_ARMED` while enable and pending are both 1. The active flag (bit 3) is 1 from the edge of the accepted start until the edge at which `eng_done` is seen.
- R11: The sequencer leaves `ST_IDLE` for `ST_ARMED` one edge after enable and pending are both 1, and returns to `ST_OFF` whenever `pwr_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Global controller power bit |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| bus_sel | input | 3 | Bit number for a single-bit access |
| bus_wdata | input | 8 | Byte write data; bit 0 carries the value of a bit write |
| bus_rdata | output | 8 | Current register value |
| hw_req | input | 1 | Selected hardware request input |
| start_req | output | 1 | Start request to the transfer engine |
| eng_start_ack | input | 1 | Engine accepts the start |
| eng_done | input | 1 | Engine reports transfer completion |
| irq | output | 1 | Channel interrupt output |

## Verification
A stale pending flag appears at bit 4 of the read data one edge after the event that should have changed it. If the flag is left set, `start_req` rises one edge after that, with no request behind it. A sequencer stuck in `ST_BUSY` or `ST_ARMED` keeps bit 3 or `start_req` at the wrong value from the first cycle after the edge that should have moved it. A mode bit that changed while powered, or a pulse register that misses or repeats a beat, shows at `irq` within the cycle after `eng_done`. Every check therefore samples one edge after its stimulus.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int REG_W   = 8;
    localparam int SEL_W   = $clog2(REG_W);

    localparam int F_EN    = 0;
    localparam int F_TRIG  = 1;
    localparam int F_FCLR  = 2;
    localparam int F_ACT   = 3;
    localparam int F_PEND  = 4;
    localparam int F_MODE  = 5;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_BUSY  = 2'd3
    } dcc_state_e;

endpackage

// File: rtl/dcc_access.sv
module dcc_access #(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input  logic          bus_wr,
    input  logic          bus_bit,
    input  logic [SW-1:0] bus_sel,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  wmask,
    output logic [W-1:0]  wval
);

    // Per-bit write strobe and value: a byte access hits every bit,
    // a bit access hits only the selected one and takes bus_wdata[0].
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (bus_bit) begin
                wmask[i] = bus_wr && (bus_sel == SW'(i));
                wval[i]  = bus_wdata[0];
            end else begin
                wmask[i] = bus_wr;
                wval[i]  = bus_wdata[i];
            end
        end
    end

endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
    import dcc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_on,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wval,
    output logic         en_q,
    output logic         fclr_q,
    output logic         mode_q,
    output logic         trig_set,
    output logic         fclr_clr
);

    // Strobes derived from this cycle's write, gated by power.
    always_comb begin
        trig_set = pwr_on && wmask[F_TRIG] &&  wval[F_TRIG];
        fclr_clr = pwr_on && wmask[F_FCLR] && !wval[F_FCLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fclr_q <= 1'b0;
        end else if (!pwr_on) begin
            en_q   <= 1'b0;
            fclr_q <= 1'b0;
        end else begin
            if (wmask[F_EN])   en_q   <= wval[F_EN];
            if (wmask[F_FCLR]) fclr_q <= wval[F_FCLR];
        end
    end

    // Mode select: writable only while powered down, untouched by power.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (!pwr_on && wmask[F_MODE]) begin
            mode_q <= wval[F_MODE];
        end
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |=> $stable(mode_q));                               // R7
    AST_OFF_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!en_q && !fclr_q));                           // R6

endmodule

// File: rtl/dcc_pend.sv
module dcc_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic hw_req,
    input  logic trig_set,
    input  logic fclr_clr,
    input  logic start_clr,
    output logic pend_q
);

    logic req_d;
    logic set_evt;
    logic clr_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= hw_req;
    end

    always_comb begin
        set_evt = (hw_req && !req_d) || trig_set;
        clr_evt = start_clr || fclr_clr;
    end

    // Set has priority over clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!pwr_on) begin
            pend_q <= 1'b0;
        end else if (set_evt) begin
            pend_q <= 1'b1;
        end else if (clr_evt) begin
            pend_q <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && set_evt) |=> pend_q);                           // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && clr_evt && !set_evt) |=> !pend_q);              // R5
    AST_OFF_PEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !pend_q);                                      // R6

endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
    import dcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic en_q,
    input  logic pend_q,
    input  logic eng_start_ack,
    input  logic eng_done,
    output logic start_req,
    output logic start_clr,
    output logic active,
    output logic irq_pulse
);

    dcc_state_e state_q;
    dcc_state_e state_d;
    logic       done_hit;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (pwr_on) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!pwr_on)              state_d = ST_OFF;
                else if (en_q && pend_q)  state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!pwr_on)                state_d = ST_OFF;
                else if (start_clr)         state_d = ST_BUSY;
                else if (!(en_q && pend_q)) state_d = ST_IDLE;
            end
            ST_BUSY: begin
                if (!pwr_on)       state_d = ST_OFF;
                else if (eng_done) state_d = ST_IDLE;
            end
            default:               state_d = ST_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        start_req = 1'b0;
        active    = 1'b0;
        done_hit  = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_IDLE:  ;
            ST_ARMED: start_req = pwr_on && en_q && pend_q;
            ST_BUSY: begin
                active   = 1'b1;
                done_hit = pwr_on && eng_done && en_q;
            end
            default:  ;
        endcase
        start_clr = start_req && eng_start_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= done_hit;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);                                 // R9
    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && eng_done) |=> !active);                         // R10
    AST_START_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_clr && pwr_on) |=> active);                         // R10
    AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!active && !start_req));                      // R11

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             bus_wr,
    input  logic             bus_bit,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             hw_req,
    output logic             start_req,
    input  logic             eng_start_ack,
    input  logic             eng_done,
    output logic             irq
);

    logic [REG_W-1:0] wmask;
    logic [REG_W-1:0] wval;
    logic en_q, fclr_q, mode_q, trig_set, fclr_clr;
    logic pend_q, start_clr, active, irq_pulse;

    dcc_access #(.W(REG_W), .SW(SEL_W)) u_access (
        .bus_wr    (bus_wr),
        .bus_bit   (bus_bit),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .wmask     (wmask),
        .wval      (wval)
    );

    dcc_regs #(.W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .wmask    (wmask),
        .wval     (wval),
        .en_q     (en_q),
        .fclr_q   (fclr_q),
        .mode_q   (mode_q),
        .trig_set (trig_set),
        .fclr_clr (fclr_clr)
    );

    dcc_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .hw_req    (hw_req),
        .trig_set  (trig_set),
        .fclr_clr  (fclr_clr),
        .start_clr (start_clr),
        .pend_q    (pend_q)
    );

    dcc_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_on        (pwr_on),
        .en_q          (en_q),
        .pend_q        (pend_q),
        .eng_start_ack (eng_start_ack),
        .eng_done      (eng_done),
        .start_req     (start_req),
        .start_clr     (start_clr),
        .active        (active),
        .irq_pulse     (irq_pulse)
    );

    // Read view; trigger and the top two bits always read 0.
    always_comb begin
        bus_rdata         = '0;
        bus_rdata[F_EN]   = en_q;
        bus_rdata[F_FCLR] = fclr_q;
        bus_rdata[F_ACT]  = active;
        bus_rdata[F_PEND] = pend_q;
        bus_rdata[F_MODE] = mode_q;
    end

    assign irq = mode_q ? irq_pulse : hw_req;

    AST_START_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (bus_rdata[F_EN] && bus_rdata[F_PEND]));     // R10
    AST_MODE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !active) |=> !irq || $past(active));            // R9

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_bit = 1'b0;
    logic [2:0] bus_sel = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       hw_req = 1'b0;
    logic       start_req;
    logic       eng_start_ack = 1'b0;
    logic       eng_done = 1'b0;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_chan_ctl u_dma_chan_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_on        (pwr_on),
        .bus_wr        (bus_wr),
        .bus_bit       (bus_bit),
        .bus_sel       (bus_sel),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .hw_req        (hw_req),
        .start_req     (start_req),
        .eng_start_ack (eng_start_ack),
        .eng_done      (eng_done),
        .irq           (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        bus_wr = 1'b1; bus_bit = 1'b0; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic write_bit(input logic [2:0] sel, input logic v);
        bus_wr = 1'b1; bus_bit = 1'b1; bus_sel = sel; bus_wdata = {7'd0, v};
        step();
        bus_wr = 1'b0; bus_bit = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1", "reset rdata", bus_rdata, 8'h00);
        chk("R11", "reset start_req", {7'd0, start_req}, 8'h00);
        chk("R8", "reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_power_off_hold();
        write_byte(8'hC7);
        chk("R6", "off write ignored", bus_rdata, 8'h00);
        write_byte(8'h20);
        chk("R7", "mode write while off", bus_rdata, 8'h20);
        write_byte(8'h00);
        chk("R7", "mode cleared while off", bus_rdata, 8'h00);
    endtask

    task automatic t_mode_lock();
        pwr_on = 1'b1;
        step();
        write_byte(8'h20);
        chk("R7", "mode write while on ignored", bus_rdata, 8'h00);
    endtask

    task automatic t_byte_bit();
        write_byte(8'h05);
        chk("R2", "byte write en+fclr", bus_rdata, 8'h05);
        write_bit(3'd0, 1'b0);
        chk("R3", "bit write clears en only", bus_rdata, 8'h04);
        write_bit(3'd7, 1'b1);
        chk("R3", "bit7 write ignored", bus_rdata, 8'h04);
        write_bit(3'd4, 1'b1);
        chk("R3", "pend bit write ignored", bus_rdata, 8'h04);
        write_bit(3'd3, 1'b1);
        chk("R2", "active bit write ignored", bus_rdata, 8'h04);
    endtask

    task automatic t_trigger();
        write_bit(3'd1, 1'b1);
        chk("R4", "trigger sets pend, reads 0", bus_rdata, 8'h14);
        write_bit(3'd2, 1'b0);
        chk("R5", "fclr 0 clears pend", bus_rdata, 8'h00);
        write_bit(3'd2, 1'b1);
        chk("R3", "fclr set again", bus_rdata, 8'h04);
    endtask

    task automatic t_set_wins();
        write_byte(8'h02);
        chk("R5", "set wins over clear", bus_rdata, 8'h10);
        write_byte(8'h04);
        chk("R5", "fclr 1 does not clear", bus_rdata, 8'h14);
        write_bit(3'd2, 1'b0);
        write_bit(3'd2, 1'b1);
        chk("R5", "cleared and restored", bus_rdata, 8'h04);
    endtask

    task automatic t_hw_edge();
        hw_req = 1'b1;
        step();
        chk("R4", "hw edge sets pend", bus_rdata, 8'h14);
        chk("R8", "mirror high", {7'd0, irq}, 8'h01);
        write_bit(3'd2, 1'b0);
        step();
        chk("R4", "held level no reset", bus_rdata, 8'h00);
        write_bit(3'd2, 1'b1);
        hw_req = 1'b0;
        step();
        chk("R8", "mirror low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_mirror_busy();
        write_bit(3'd0, 1'b1);
        write_bit(3'd1, 1'b1);
        chk("R4", "pend with en", bus_rdata, 8'h15);
        chk("R11", "not armed yet", {7'd0, start_req}, 8'h00);
        step();
        chk("R10", "start_req armed", {7'd0, start_req}, 8'h01);
        hw_req = 1'b1;
        #1;
        chk("R8", "mirror in armed", {7'd0, irq}, 8'h01);
        hw_req = 1'b0;
        eng_start_ack = 1'b1;
        step();
        eng_start_ack = 1'b0;
        chk("R10", "busy rdata", bus_rdata, 8'h0D);
        chk("R10", "start_req dropped", {7'd0, start_req}, 8'h00);
        hw_req = 1'b1;
        step();
        chk("R8", "mirror in busy", {7'd0, irq}, 8'h01);
        chk("R4", "hw edge during busy", bus_rdata, 8'h1D);
        hw_req = 1'b0;
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        chk("R10", "active ends", bus_rdata, 8'h15);
        chk("R8", "mirror no pulse", {7'd0, irq}, 8'h00);
        write_bit(3'd2, 1'b0);
        chk("R5", "pend cleared", bus_rdata, 8'h01);
        write_bit(3'd2, 1'b1);
        step();
        chk("R10", "no start without pend", {7'd0, start_req}, 8'h00);
    endtask

    task automatic t_exec_irq();
        pwr_on = 1'b0;
        step();
        chk("R6", "power drop clears", bus_rdata, 8'h00);
        write_byte(8'h20);
        pwr_on = 1'b1;
        step();
        write_bit(3'd0, 1'b1);
        write_bit(3'd2, 1'b1);
        write_bit(3'd1, 1'b1);
        chk("R4", "pend in mode 1", bus_rdata, 8'h35);
        step();
        chk("R11", "armed in mode 1", {7'd0, start_req}, 8'h01);
        hw_req = 1'b1;
        #1;
        chk("R9", "no mirror in mode 1", {7'd0, irq}, 8'h00);
        step();
        hw_req = 1'b0;
        eng_start_ack = 1'b1;
        step();
        eng_start_ack = 1'b0;
        chk("R10", "busy mode 1", bus_rdata, 8'h2D);
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        chk("R9", "pulse after done", {7'd0, irq}, 8'h01);
        chk("R10", "idle after done", bus_rdata, 8'h25);
        step();
        chk("R9", "pulse one cycle", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_no_irq_disabled();
        write_bit(3'd1, 1'b1);
        step();
        chk("R10", "armed again", {7'd0, start_req}, 8'h01);
        eng_start_ack = 1'b1;
        step();
        eng_start_ack = 1'b0;
        write_bit(3'd0, 1'b0);
        chk("R10", "busy, en off", bus_rdata, 8'h2C);
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        chk("R9", "no pulse when disabled", {7'd0, irq}, 8'h00);
        chk("R10", "idle, disabled", bus_rdata, 8'h24);
        pwr_on = 1'b0;
        step();
        chk("R6", "off keeps mode only", bus_rdata, 8'h20);
    endtask

    initial begin
        #(5 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_power_off_hold();
        t_mode_lock();
        t_byte_bit();
        t_trigger();
        t_set_wins();
        t_hw_edge();
        t_mirror_busy();
        t_exec_irq();
        t_no_irq_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule